// File: doc/BRIEF.md
# Paged PMBus Command Target

This block is the transaction layer of a PMBus target for a device with two outputs that share one bus address. An external I2C bit engine handles SCL and SDA and reports byte-level events. It signals a start or repeated start, a stop, and each received byte. It also signals when it has shifted out the byte the target offers. The block returns an ACK decision for every received byte and presents the byte to send during reads. The byte after each start is taken as the address byte.

The target decodes byte and word writes and reads. A page register selects which output an access reaches: the first, the second, or both. Every transaction carries an SMBus packet error code. Writes are held in a staging buffer and are applied at stop, and only if the code checks out. A failed check sets a communication-fault flag, and that flag pulls the active-low alert line low. The host clears the alert by reading the alert response address.

Command codes: 0x00 selects the page register (one byte). 0x01 is a read-only status byte whose bit 0 is the communication-fault flag. Commands 0x20 to 0x20+NREG-1 are 16-bit per-output registers; NREG is 4 by default.

Top module: `pmbus_page_target`

## Requirements
- R1: After reset the page register is 0x00, every word register of both outputs is 0x0000, the fault flag is clear, alert_n is high, ack is low and tx_byte is 0xFF.
- R2: An address byte is ACKed (ack high the cycle after the byte) in two cases. The first is a write address whose upper seven bits equal dev_addr. The second is a read address equal to dev_addr that directly follows, after a repeated start, a write address and a command byte of the same transaction. Every other address byte is NACKed, and the bytes after it are NACKed and have no effect.
- R3: The page register holds two writable bits: PA in data bit 7 and P0 in data bit 0. Page value 00 sends reads and writes of the word registers to the first output, and 01 sends them to the second.
- R4: With page value 11 (PAGE reads back 0x81), a word write updates both outputs and a word read returns the first output's value.
- R5: A page write with PA=1 and P0=0 is ignored and the previous page value is kept. Bits 6 to 1 of a page write are discarded and always read as 0.
- R6: Writes to the status command 0x01 are ignored and leave its value unchanged.
- R7: Every read returns its data bytes followed by a PEC byte. The PEC is CRC-8 with polynomial 0x07 and initial value 0x00, taken over the write address, the command, the read address and the data bytes.
- R8: A write is discarded if its last byte does not equal the CRC-8 of the bytes before it, or if its data length does not fit the command (1 byte for 0x00/0x01, 2 bytes for word registers). Either case sets status bit 0 and drives alert_n low.
- R9: While the fault flag is set, a read of address 0x0C (byte 0x19) is ACKed and returns dev_addr shifted left by one, followed by its PEC. Once that first byte is taken, the fault flag clears and alert_n goes high. While the fault flag is clear, the address 0x19 is NACKed.
- R10: A write is applied only at a stop. Data staged before a repeated start is dropped.
- R11: A command byte other than 0x00, 0x01 or a word-register code is NACKed, and the bytes after it are NACKed and have no effect.
- R12: Word data is sent in both directions with the low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Strapped 7-bit device address |
| ev_start | input | 1 | One-cycle pulse: start or repeated start seen |
| ev_stop | input | 1 | One-cycle pulse: stop seen |
| ev_byte | input | 1 | One-cycle pulse: a byte was received on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | One-cycle pulse: the byte on tx_byte has been sent |
| ack | output | 1 | ACK (1) or NACK (0) for the last received byte |
| tx_byte | output | 8 | Byte to transmit during a read |
| alert_n | output | 1 | Active-low alert, low while the fault flag is set |

## Verification
The assertions assume the bit engine raises at most one event in a cycle, and that every event is a single-cycle pulse. They also assume a byte arriving after a start is the address byte. The checks on alert edges further assume that only a stop can set the fault and only a taken byte can clear it. The bench drives each event for exactly one cycle with an idle cycle after it. It opens every transaction with a start and ends it with a stop or a repeated start, so the stimulus never overlaps events or sends bytes outside a transaction.

// File: rtl/pmbus_page_target.sv
module pmbus_page_target #(
  parameter int NREG = 4,
  parameter logic [7:0] WBASE = 8'h20,
  parameter logic [6:0] ARA = 7'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       tx_take,
  output logic       ack,
  output logic [7:0] tx_byte,
  output logic       alert_n
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {P_IDLE, P_ADR, P_CMD, P_WDAT, P_RD, P_ARA} ph_t;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic logic is_word(input logic [7:0] c);
    return (int'(c) >= int'(WBASE)) && (int'(c) < int'(WBASE) + NREG);
  endfunction

  function automatic logic [1:0] cmd_len(input logic [7:0] c);
    if (is_word(c)) return 2'd2;
    if (c == 8'h00 || c == 8'h01) return 2'd1;
    return 2'd0;
  endfunction

  ph_t ph;
  logic cont, fault, ack_q;
  logic [7:0] cmd_q, crc;
  logic [15:0] stage;
  logic [2:0] cnt;
  logic [1:0] ridx, page;
  logic [NREG-1:0][15:0] rf0, rf1;

  logic [IW-1:0] widx;
  logic [1:0] len_q;
  logic [15:0] rdata;
  logic wr_ok;

  assign widx  = cmd_q[IW-1:0] - WBASE[IW-1:0];
  assign len_q = cmd_len(cmd_q);
  assign rdata = (cmd_q == 8'h00) ? {8'h00, page[1], 6'b0, page[0]} :
                 (cmd_q == 8'h01) ? {15'b0, fault} :
                 (page == 2'b01)  ? rf1[widx] : rf0[widx];
  assign wr_ok = (cnt == {1'b0, len_q} + 3'd1) && (crc == 8'h00);

  assign tx_byte = (ph == P_RD)  ? ((ridx < len_q) ? ((ridx == 2'd0) ? rdata[7:0] : rdata[15:8]) : crc) :
                   (ph == P_ARA) ? ((ridx == 2'd0) ? {dev_addr, 1'b0} : crc) : 8'hFF;
  assign ack     = ack_q;
  assign alert_n = ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; cont <= 1'b0; fault <= 1'b0; ack_q <= 1'b0;
      cmd_q <= 8'h00; crc <= 8'h00; stage <= 16'h0; cnt <= 3'd0;
      ridx <= 2'd0; page <= 2'b00; rf0 <= '0; rf1 <= '0;
    end else if (ev_stop) begin
      if (ph == P_WDAT && cnt != 3'd0) begin
        if (!wr_ok) fault <= 1'b1;
        else if (cmd_q == 8'h00) begin
          if (!(stage[7] && !stage[0])) page <= {stage[7], stage[0]};
        end else if (is_word(cmd_q)) begin
          if (page != 2'b01) rf0[widx] <= stage;
          if (page != 2'b00) rf1[widx] <= stage;
        end
      end
      ph <= P_IDLE;
      cont <= 1'b0;
    end else if (ev_start) begin
      ph <= P_ADR;
      cont <= (ph == P_WDAT) && (cnt == 3'd0);
    end else if (ev_byte) begin
      ack_q <= 1'b0;
      case (ph)
        P_ADR: begin
          ridx <= 2'd0;
          cnt <= 3'd0;
          if (rx_byte[7:1] == dev_addr && !rx_byte[0]) begin
            ph <= P_CMD; ack_q <= 1'b1; crc <= crc8(8'h00, rx_byte);
          end else if (rx_byte[7:1] == dev_addr && cont) begin
            ph <= P_RD; ack_q <= 1'b1; crc <= crc8(crc, rx_byte);
          end else if (rx_byte[7:1] == ARA && rx_byte[0] && fault) begin
            ph <= P_ARA; ack_q <= 1'b1; crc <= crc8(8'h00, rx_byte);
          end else ph <= P_IDLE;
        end
        P_CMD: begin
          if (cmd_len(rx_byte) != 2'd0) begin
            ph <= P_WDAT; ack_q <= 1'b1; cmd_q <= rx_byte; crc <= crc8(crc, rx_byte);
          end else ph <= P_IDLE;
        end
        P_WDAT: begin
          ack_q <= 1'b1;
          crc <= crc8(crc, rx_byte);
          if (cnt == 3'd0) stage[7:0] <= rx_byte;
          if (cnt == 3'd1) stage[15:8] <= rx_byte;
          if (cnt != 3'd7) cnt <= cnt + 3'd1;
        end
        default: ;
      endcase
    end else if (tx_take && (ph == P_RD || ph == P_ARA)) begin
      crc <= crc8(crc, tx_byte);
      if (ridx != 2'd3) ridx <= ridx + 2'd1;
      if (ph == P_ARA && ridx == 2'd0) fault <= 1'b0;
    end
  end
endmodule

// File: rtl/pmbus_page_target_chk.sv
module pmbus_page_target_chk #(
  parameter int NREG = 4,
  parameter logic [6:0] ARA = 7'h0C
) (
  input logic             clk,
  input logic             rst_n,
  input logic [6:0]       dev_addr,
  input logic             ev_stop,
  input logic             ev_byte,
  input logic [7:0]       rx_byte,
  input logic             tx_take,
  input logic             ack,
  input logic             alert_n,
  input logic [2:0]       ph,
  input logic [1:0]       page,
  input logic [NREG*16-1:0] rf0,
  input logic [NREG*16-1:0] rf1
);
  AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) page != 2'b10); // R5
  AST_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && ph == 3'd1 && rx_byte[7:1] != dev_addr && rx_byte[7:1] != ARA) |=> !ack); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ev_byte |=> $stable(ack)); // R2
  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_stop |=> ($stable(rf0) && $stable(rf1) && $stable(page))); // R10
  AST_ALERT_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(ev_stop)); // R8
  AST_ALERT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> $past(tx_take)); // R9
endmodule

bind pmbus_page_target pmbus_page_target_chk #(.NREG(NREG), .ARA(ARA)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .ev_stop(ev_stop), .ev_byte(ev_byte),
  .rx_byte(rx_byte), .tx_take(tx_take), .ack(ack), .alert_n(alert_n), .ph(ph),
  .page(page), .rf0(rf0), .rf1(rf1)
);

// File: tb/pmbus_page_target_test.sv
module pmbus_page_target_test;
  localparam logic [6:0] DEV = 7'h40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, tx_take = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic ack, alert_n;
  logic [7:0] tx_byte;

  pmbus_page_target uut (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .tx_take(tx_take), .ack(ack),
    .tx_byte(tx_byte), .alert_n(alert_n)
  );

  int checks = 0, errors = 0;
  logic exp_ack_q[$];
  string ack_tag_q[$];
  logic [7:0] exp_tx_q[$];
  string tx_tag_q[$];
  logic [7:0] crc_h;
  logic byte_prev = 1'b0;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (byte_prev) begin
      if (exp_ack_q.size() == 0) chk(1'b0, "unexpected ack", {15'b0, ack}, 16'h0);
      else begin
        logic e;
        string t;
        e = exp_ack_q.pop_front();
        t = ack_tag_q.pop_front();
        chk(ack === e, t, {15'b0, ack}, {15'b0, e});
      end
    end
    if (tx_take) begin
      if (exp_tx_q.size() == 0) chk(1'b0, "unexpected tx", {8'h0, tx_byte}, 16'h0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_tx_q.pop_front();
        t = tx_tag_q.pop_front();
        chk(tx_byte === e, t, {8'h0, tx_byte}, {8'h0, e});
      end
    end
    byte_prev = ev_byte;
  end

  task automatic do_start();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0; @(negedge clk);
  endtask

  task automatic do_stop();
    ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0; @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic a, input string tag);
    crc_h = crc8(crc_h, b);
    exp_ack_q.push_back(a);
    ack_tag_q.push_back(tag);
    rx_byte = b; ev_byte = 1'b1; @(negedge clk); ev_byte = 1'b0; @(negedge clk);
  endtask

  task automatic take(input logic [7:0] e, input string tag);
    exp_tx_q.push_back(e);
    tx_tag_q.push_back(tag);
    tx_take = 1'b1; @(negedge clk); tx_take = 1'b0; @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] cmd, input int n, input logic [15:0] d, input bit bad, input string tag);
    crc_h = 8'h00;
    do_start();
    send({DEV, 1'b0}, 1'b1, tag);
    send(cmd, 1'b1, tag);
    for (int i = 0; i < n; i++) send(d[8*i +: 8], 1'b1, tag);
    send(bad ? (crc_h ^ 8'h01) : crc_h, 1'b1, tag);
    do_stop();
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, input logic [15:0] d, input string tag);
    crc_h = 8'h00;
    do_start();
    send({DEV, 1'b0}, 1'b1, tag);
    send(cmd, 1'b1, tag);
    do_start();
    send({DEV, 1'b1}, 1'b1, tag);
    for (int i = 0; i < n; i++) begin
      crc_h = crc8(crc_h, d[8*i +: 8]);
      take(d[8*i +: 8], tag);
    end
    take(crc_h, {tag, " R7 pec"});
    do_stop();
  endtask

  task automatic ara_read(input string tag);
    crc_h = 8'h00;
    do_start();
    send(8'h19, 1'b1, tag);
    crc_h = crc8(crc_h, {DEV, 1'b0});
    take({DEV, 1'b0}, tag);
    take(crc_h, {tag, " R7 pec"});
    do_stop();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(alert_n === 1'b1, "R1 alert_n", {15'b0, alert_n}, 16'h1);
    chk(ack === 1'b0, "R1 ack", {15'b0, ack}, 16'h0);
    chk(tx_byte === 8'hFF, "R1 tx_byte", {8'h0, tx_byte}, 16'h00FF);
    rd(8'h00, 1, 16'h0000, "R1 page reset");
    rd(8'h20, 2, 16'h0000, "R1 word reset");

    wr(8'h20, 2, 16'h1234, 0, "R3 write out1");
    wr(8'h00, 1, 16'h0001, 0, "R3 page 01");
    wr(8'h20, 2, 16'hABCD, 0, "R3 write out2");
    rd(8'h20, 2, 16'hABCD, "R3 R12 read out2");
    wr(8'h00, 1, 16'h0000, 0, "R3 page 00");
    rd(8'h20, 2, 16'h1234, "R3 R12 read out1");

    wr(8'h00, 1, 16'h0081, 0, "R4 page 11");
    rd(8'h00, 1, 16'h0081, "R4 page readback");
    rd(8'h20, 2, 16'h1234, "R4 read first");
    wr(8'h21, 2, 16'h5A3C, 0, "R4 write both");
    wr(8'h00, 1, 16'h0001, 0, "R4 page 01");
    rd(8'h21, 2, 16'h5A3C, "R4 out2 got both-write");
    wr(8'h00, 1, 16'h0081, 0, "R4 page 11 again");

    wr(8'h00, 1, 16'h0080, 0, "R5 illegal page");
    rd(8'h00, 1, 16'h0081, "R5 page kept");
    wr(8'h00, 1, 16'h007E, 0, "R5 ro bits");
    rd(8'h00, 1, 16'h0000, "R5 ro bits read 0");
    wr(8'h00, 1, 16'h0080, 0, "R5 illegal page 2");
    rd(8'h00, 1, 16'h0000, "R5 page kept 2");

    wr(8'h01, 1, 16'h00FF, 0, "R6 status write");
    rd(8'h01, 1, 16'h0000, "R6 status unchanged");
    chk(alert_n === 1'b1, "R6 alert_n", {15'b0, alert_n}, 16'h1);

    do_start(); send(8'h19, 1'b0, "R9 ara nack when idle"); do_stop();

    wr(8'h20, 2, 16'hDEAD, 1, "R8 bad pec");
    chk(alert_n === 1'b0, "R8 alert_n low", {15'b0, alert_n}, 16'h0);
    rd(8'h01, 1, 16'h0001, "R8 status fault");
    rd(8'h20, 2, 16'h1234, "R8 write discarded");
    ara_read("R9 ara");
    chk(alert_n === 1'b1, "R9 alert released", {15'b0, alert_n}, 16'h1);
    rd(8'h01, 1, 16'h0000, "R9 fault cleared");

    wr(8'h21, 1, 16'h00AA, 0, "R8 short write");
    chk(alert_n === 1'b0, "R8 alert on length", {15'b0, alert_n}, 16'h0);
    rd(8'h21, 2, 16'h5A3C, "R8 short discarded");
    ara_read("R9 ara 2");

    crc_h = 8'h00;
    do_start();
    send({7'h41, 1'b0}, 1'b0, "R2 foreign addr");
    send(8'h20, 1'b0, "R2 foreign cmd");
    send(8'h77, 1'b0, "R2 foreign data");
    do_stop();
    do_start(); send({DEV, 1'b1}, 1'b0, "R2 read without cmd"); do_stop();
    rd(8'h20, 2, 16'h1234, "R2 no effect");

    crc_h = 8'h00;
    do_start();
    send({DEV, 1'b0}, 1'b1, "R11 addr");
    send(8'h55, 1'b0, "R11 unknown cmd");
    send(8'h11, 1'b0, "R11 data nack");
    do_stop();
    chk(alert_n === 1'b1, "R11 no fault", {15'b0, alert_n}, 16'h1);

    crc_h = 8'h00;
    do_start();
    send({DEV, 1'b0}, 1'b1, "R10 first");
    send(8'h20, 1'b1, "R10 first");
    send(8'h99, 1'b1, "R10 first");
    send(8'h98, 1'b1, "R10 first");
    send(crc_h, 1'b1, "R10 first pec");
    crc_h = 8'h00;
    do_start();
    send({DEV, 1'b0}, 1'b1, "R10 second");
    send(8'h21, 1'b1, "R10 second");
    send(8'h02, 1'b1, "R10 second");
    send(8'h01, 1'b1, "R10 second");
    send(crc_h, 1'b1, "R10 second pec");
    do_stop();
    rd(8'h20, 2, 16'h1234, "R10 staged dropped");
    rd(8'h21, 2, 16'h0102, "R10 R12 second applied");
    chk(alert_n === 1'b1, "R10 no fault", {15'b0, alert_n}, 16'h1);

    repeat (2) @(negedge clk);
    chk(exp_ack_q.size() == 0 && exp_tx_q.size() == 0, "R2 scoreboard drained",
        16'(exp_ack_q.size() + exp_tx_q.size()), 16'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule